// File: doc/BRIEF.md
# UART Transmit and Receive Holding Queues

This block holds the bytes that pass between a host register port and a UART serial engine. The transmit queue is filled by host writes and drained by the transmitter. The receive queue is filled by the receiver and drained by host reads. Both queues share one control register with three bits. One bit chooses between a single-byte holding register and a FIFO. Two bits are flush commands that clear themselves. In FIFO mode a depth-select input picks 16 or 128 entries; its value is latched on each control write.

Each queue reports empty, full and an 8-bit occupancy level. A byte that the receiver delivers into a full receive queue is dropped, and a sticky overrun flag is raised; a clear strobe lowers it again. The transmitter counts as idle when the transmit queue is empty and the serial engine says its shift register is empty.

A flush command takes effect on the clock edge after the control write. During that one cycle the flush bit reads back as one.

Top module: `uart_holdq`

## Requirements
- R1: After reset the block is in byte mode with both queues empty, both levels 0, the overrun flag low and `cfg_rdata` equal to 0. In byte mode (`cfg_wdata[0]`=0) each queue holds one byte and reports full once it holds that byte.
- R2: A control write with `cfg_wdata[0]`=1 selects FIFO mode. The capacity is 16 if `depth_sel` was 0 at that write, or 128 if it was 1. `cfg_rdata[3]` shows the latched depth select and `cfg_rdata[0]` shows the mode.
- R3: A host write to a full transmit queue is discarded: the level does not change and the bytes already queued come out unaltered.
- R4: A host read of an empty receive queue changes no pointer: the level stays 0, and the next byte received is the next byte read.
- R5: A control write with `cfg_wdata[1]`=1, made while FIFO mode is already active, empties the receive queue on the following edge. `cfg_rdata[1]` reads 1 for the cycle in between and 0 afterwards.
- R6: In byte mode, a receive flush request (`cfg_wdata[1]`=1 with `cfg_wdata[0]`=0) is ignored: `cfg_rdata[1]` stays 0 and the held byte stays.
- R7: A control write with `cfg_wdata[2]`=1, made while FIFO mode is active, empties the transmit queue on the following edge. `cfg_rdata[2]` reads 1 for one cycle and then returns to 0.
- R8: Any control write that changes `cfg_wdata[0]` relative to the current mode flushes the receive queue on the following edge. The transmit queue is kept.
- R9: A receive push into a full queue drops the byte, keeps the queued data and sets `rx_overrun`. The flag stays set until `ovr_clr` is pulsed; if a new overrun occurs in the same cycle as the clear, the flag stays set.
- R10: `tx_level` and `rx_level` equal the number of bytes held. `*_empty` is high when the level is 0, and `*_full` is high when the level has reached the capacity.
- R11: `tx_idle` is high exactly when the transmit queue is empty and `tsr_empty` is high.
- R12: Each queue returns bytes in arrival order, including when the pointers wrap around the 128-entry storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 3 | Control bits: [0] FIFO mode, [1] receive flush, [2] transmit flush |
| depth_sel | input | 1 | FIFO depth select, latched on each control write (0: 16, 1: 128) |
| cfg_rdata | output | 4 | Control readback: [0] mode, [1] receive flush pending, [2] transmit flush pending, [3] depth |
| tx_wr | input | 1 | Host write strobe into the transmit queue |
| tx_wdata | input | 8 | Host write byte |
| tx_pop | input | 1 | Transmitter takes the head byte |
| tx_pdata | output | 8 | Head byte of the transmit queue |
| tsr_empty | input | 1 | Shift register of the serial engine is empty |
| tx_idle | output | 1 | Transmitter idle |
| tx_empty | output | 1 | Transmit queue empty |
| tx_full | output | 1 | Transmit queue full |
| tx_level | output | 8 | Transmit queue occupancy |
| rx_push | input | 1 | Receiver delivers a byte |
| rx_pdata | input | 8 | Received byte |
| rx_rd | input | 1 | Host read strobe from the receive queue |
| rx_rdata | output | 8 | Head byte of the receive queue |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive queue full |
| rx_level | output | 8 | Receive queue occupancy |
| rx_overrun | output | 1 | Sticky receive overrun flag |
| ovr_clr | input | 1 | Clears the overrun flag |

## Verification
The bench writes past capacity in byte mode, at depth 16 and at depth 128. If the design applied the wrong capacity, or let a discarded byte overwrite queued data, the level or the scoreboard order would differ from the expected values. It sends flush requests in byte mode, where they must do nothing, and in FIFO mode, where they must clear the queue and read back as 1 for exactly one cycle; a design that flushed unconditionally would lose the held byte. It checks that toggling the mode clears only the receive side, and it drives the receive pointers around the end of the 128-entry storage, where a wrap fault would return bytes out of order. It also tests whether the overrun flag is sticky.

// File: rtl/uhq_pkg.sv
package uhq_pkg;

  typedef struct packed {
    logic fifo_en;
    logic deep;
    logic rx_flush;
    logic tx_flush;
  } hq_ctrl_t;

  // capacity of one queue for the current mode
  function automatic int hq_cap(input logic fifo_en, input logic deep,
                                input int shallow_d, input int deep_d);
    if (!fifo_en) return 1;
    return deep ? deep_d : shallow_d;
  endfunction

  // next occupancy given accepted push and pop
  function automatic int hq_next_lvl(input int lvl, input logic inc, input logic dec);
    return lvl + (inc ? 1 : 0) - (dec ? 1 : 0);
  endfunction

  // circular pointer step over the physical storage
  function automatic int hq_ptr_step(input int ptr, input int depth);
    return (ptr == depth - 1) ? 0 : ptr + 1;
  endfunction

endpackage

// File: rtl/uhq_ctrl.sv
module uhq_ctrl
  import uhq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic [2:0] cfg_wdata,
  input  logic       depth_sel,
  output hq_ctrl_t   ctrl,
  output logic [3:0] cfg_rdata
);

  logic fifo_q, deep_q, rx_pend_q, tx_pend_q;
  logic mode_chg;   // write that toggles between byte and FIFO mode
  logic rx_fl_req;
  logic tx_fl_req;

  assign mode_chg  = cfg_wr && (cfg_wdata[0] != fifo_q);
  assign rx_fl_req = mode_chg || (cfg_wr && cfg_wdata[1] && fifo_q);
  assign tx_fl_req = cfg_wr && cfg_wdata[2] && fifo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_q    <= 1'b0;
      deep_q    <= 1'b0;
      rx_pend_q <= 1'b0;
      tx_pend_q <= 1'b0;
    end else begin
      if (cfg_wr) begin
        fifo_q <= cfg_wdata[0];
        deep_q <= depth_sel;
      end
      rx_pend_q <= rx_fl_req;
      tx_pend_q <= tx_fl_req;
    end
  end

  assign ctrl.fifo_en  = fifo_q;
  assign ctrl.deep     = deep_q;
  assign ctrl.rx_flush = rx_pend_q;
  assign ctrl.tx_flush = tx_pend_q;
  assign cfg_rdata     = {deep_q, tx_pend_q, rx_pend_q, fifo_q};

  AST_RX_PEND_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pend_q && !cfg_wr |=> !rx_pend_q); // R5
  AST_TX_PEND_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pend_q && !cfg_wr |=> !tx_pend_q); // R7
  AST_BYTE_FLUSH_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && !fifo_q && !cfg_wdata[0] |=> !rx_pend_q && !tx_pend_q); // R6
  AST_MODE_CHANGE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> rx_pend_q); // R8

endmodule

// File: rtl/uhq_queue.sv
module uhq_queue
  import uhq_pkg::*;
#(
  parameter int DEPTH_MAX = 128,
  parameter int DW        = 8,
  parameter int LVL_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] cap,
  input  logic             flush,
  input  logic             push,
  input  logic [DW-1:0]    wdata,
  input  logic             pop,
  output logic [DW-1:0]    rdata,
  output logic             empty,
  output logic             full,
  output logic             push_drop,
  output logic [LVL_W-1:0] level
);

  localparam int PW = (DEPTH_MAX > 1) ? $clog2(DEPTH_MAX) : 1;

  logic [DW-1:0]    mem [DEPTH_MAX];
  logic [PW-1:0]    wp, rp;
  logic [LVL_W-1:0] lvl;
  logic             push_ok, pop_ok;

  assign empty     = (lvl == '0);
  assign full      = (lvl >= cap);
  assign push_ok   = push && !full && !flush;
  assign pop_ok    = pop && !empty && !flush;
  assign push_drop = push && full && !flush;
  assign rdata     = mem[rp];
  assign level     = lvl;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      lvl <= '0;
    end else if (flush) begin
      wp  <= '0;
      rp  <= '0;
      lvl <= '0;
    end else begin
      if (push_ok) wp <= PW'(hq_ptr_step(int'(wp), DEPTH_MAX));
      if (pop_ok)  rp <= PW'(hq_ptr_step(int'(rp), DEPTH_MAX));
      lvl <= LVL_W'(hq_next_lvl(int'(lvl), push_ok, pop_ok));
    end
  end

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    lvl <= LVL_W'(DEPTH_MAX)); // R10
  AST_FULL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    push_drop && !pop |=> $stable(lvl) && $stable(wp)); // R3
  AST_EMPTY_READ_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    pop && empty && !flush |=> $stable(rp)); // R4
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> lvl == '0); // R5

endmodule

// File: rtl/uart_holdq.sv
module uart_holdq
  import uhq_pkg::*;
#(
  parameter int SHALLOW_D = 16,
  parameter int DEEP_D    = 128,
  parameter int DW        = 8,
  parameter int LVL_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [2:0]       cfg_wdata,
  input  logic             depth_sel,
  output logic [3:0]       cfg_rdata,
  input  logic             tx_wr,
  input  logic [DW-1:0]    tx_wdata,
  input  logic             tx_pop,
  output logic [DW-1:0]    tx_pdata,
  input  logic             tsr_empty,
  output logic             tx_idle,
  output logic             tx_empty,
  output logic             tx_full,
  output logic [LVL_W-1:0] tx_level,
  input  logic             rx_push,
  input  logic [DW-1:0]    rx_pdata,
  input  logic             rx_rd,
  output logic [DW-1:0]    rx_rdata,
  output logic             rx_empty,
  output logic             rx_full,
  output logic [LVL_W-1:0] rx_level,
  output logic             rx_overrun,
  input  logic             ovr_clr
);

  hq_ctrl_t         ctrl;
  logic [LVL_W-1:0] cap;
  logic             tx_drop, rx_drop;
  logic             ovr_q;

  uhq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .depth_sel(depth_sel), .ctrl(ctrl), .cfg_rdata(cfg_rdata)
  );

  assign cap = LVL_W'(hq_cap(ctrl.fifo_en, ctrl.deep, SHALLOW_D, DEEP_D));

  uhq_queue #(.DEPTH_MAX(DEEP_D), .DW(DW), .LVL_W(LVL_W)) u_txq (
    .clk(clk), .rst_n(rst_n), .cap(cap), .flush(ctrl.tx_flush),
    .push(tx_wr), .wdata(tx_wdata), .pop(tx_pop), .rdata(tx_pdata),
    .empty(tx_empty), .full(tx_full), .push_drop(tx_drop), .level(tx_level)
  );

  uhq_queue #(.DEPTH_MAX(DEEP_D), .DW(DW), .LVL_W(LVL_W)) u_rxq (
    .clk(clk), .rst_n(rst_n), .cap(cap), .flush(ctrl.rx_flush),
    .push(rx_push), .wdata(rx_pdata), .pop(rx_rd), .rdata(rx_rdata),
    .empty(rx_empty), .full(rx_full), .push_drop(rx_drop), .level(rx_level)
  );

  // sticky overrun; a new drop wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovr_q <= 1'b0;
    else if (rx_drop) ovr_q <= 1'b1;
    else if (ovr_clr) ovr_q <= 1'b0;
  end

  assign rx_overrun = ovr_q;
  assign tx_idle    = tx_empty && tsr_empty;

  AST_OVR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_drop |=> rx_overrun); // R9
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun && !ovr_clr |=> rx_overrun); // R9
  AST_IDLE_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_idle |-> tx_level == '0); // R11
  AST_BYTE_MODE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdata[0] && rx_level != '0 |-> rx_full); // R1
  AST_DEEP_CAPACITY: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[0] && cfg_rdata[3] && tx_level < LVL_W'(DEEP_D) |-> !tx_full); // R2

endmodule

// File: tb/uart_holdq_tb_top.sv
module uart_holdq_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [2:0] cfg_wdata = '0;
  logic       depth_sel = 1'b0;
  logic [3:0] cfg_rdata;
  logic       tx_wr = 1'b0;
  logic [7:0] tx_wdata = '0;
  logic       tx_pop = 1'b0;
  logic [7:0] tx_pdata;
  logic       tsr_empty = 1'b1;
  logic       tx_idle, tx_empty, tx_full;
  logic [7:0] tx_level;
  logic       rx_push = 1'b0;
  logic [7:0] rx_pdata = '0;
  logic       rx_rd = 1'b0;
  logic [7:0] rx_rdata;
  logic       rx_empty, rx_full, rx_overrun;
  logic [7:0] rx_level;
  logic       ovr_clr = 1'b0;

  always #5 clk = ~clk;

  uart_holdq dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .depth_sel(depth_sel), .cfg_rdata(cfg_rdata),
    .tx_wr(tx_wr), .tx_wdata(tx_wdata), .tx_pop(tx_pop), .tx_pdata(tx_pdata),
    .tsr_empty(tsr_empty), .tx_idle(tx_idle), .tx_empty(tx_empty),
    .tx_full(tx_full), .tx_level(tx_level),
    .rx_push(rx_push), .rx_pdata(rx_pdata), .rx_rd(rx_rd), .rx_rdata(rx_rdata),
    .rx_empty(rx_empty), .rx_full(rx_full), .rx_level(rx_level),
    .rx_overrun(rx_overrun), .ovr_clr(ovr_clr)
  );

  // scoreboard model
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 0;
  logic [7:0] tx_q[$];
  logic [7:0] rx_q[$];
  bit         m_fifo = 0;
  bit         m_deep = 0;
  bit         m_ovr = 0;
  string      mon_tag = "R12";

  function automatic int m_cap();
    if (!m_fifo) return 1;
    return m_deep ? 128 : 16;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: compares head bytes as the engine and host take them
  always @(negedge clk) begin
    #3;
    if (rst_n && tx_pop && tx_q.size() > 0) chk({mon_tag, " tx byte"}, int'(tx_pdata), int'(tx_q.pop_front()));
    if (rst_n && rx_rd && rx_q.size() > 0) chk({mon_tag, " rx byte"}, int'(rx_rdata), int'(rx_q.pop_front()));
  end

  task automatic host_tx(input logic [7:0] d);
    @(negedge clk); #1;
    tx_wr = 1'b1; tx_wdata = d;
    if (tx_q.size() < m_cap()) tx_q.push_back(d);
    @(posedge clk); #1;
    tx_wr = 1'b0;
  endtask

  task automatic eng_pop();
    @(negedge clk); #1; tx_pop = 1'b1;
    @(posedge clk); #1; tx_pop = 1'b0;
  endtask

  task automatic eng_push(input logic [7:0] d);
    @(negedge clk); #1;
    rx_push = 1'b1; rx_pdata = d;
    if (rx_q.size() < m_cap()) rx_q.push_back(d); else m_ovr = 1;
    @(posedge clk); #1;
    rx_push = 1'b0;
  endtask

  task automatic host_rd();
    @(negedge clk); #1; rx_rd = 1'b1;
    @(posedge clk); #1; rx_rd = 1'b0;
  endtask

  task automatic clr_ovr();
    @(negedge clk); #1; ovr_clr = 1'b1; m_ovr = 0;
    @(posedge clk); #1; ovr_clr = 1'b0;
  endtask

  // control write; returns just after the write edge (flush pending)
  task automatic cfg(input logic [2:0] w);
    @(negedge clk); #1;
    cfg_wr = 1'b1; cfg_wdata = w;
    if ((w[1] && m_fifo) || (w[0] != m_fifo)) rx_q.delete();
    if (w[2] && m_fifo) tx_q.delete();
    m_fifo = w[0]; m_deep = depth_sel;
    @(posedge clk); #1;
    cfg_wr = 1'b0; cfg_wdata = '0;
  endtask

  task automatic status(input string tag);
    @(negedge clk); #3;
    chk({tag, " tx_level"}, int'(tx_level), tx_q.size());
    chk({tag, " rx_level"}, int'(rx_level), rx_q.size());
    chk({tag, " tx_full"}, int'(tx_full), int'(tx_q.size() >= m_cap()));
    chk({tag, " rx_full"}, int'(rx_full), int'(rx_q.size() >= m_cap()));
    chk({tag, " tx_empty"}, int'(tx_empty), int'(tx_q.size() == 0));
    chk({tag, " rx_empty"}, int'(rx_empty), int'(rx_q.size() == 0));
    chk({tag, " overrun"}, int'(rx_overrun), int'(m_ovr));
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    status("R1 reset");
    chk("R1 cfg_rdata reset", int'(cfg_rdata), 0);
    chk("R11 idle at reset", int'(tx_idle), 1);

    // R1 byte mode transmit holds one byte; R3 second write discarded
    host_tx(8'hA1);
    status("R1 byte tx one");
    chk("R11 not idle with data", int'(tx_idle), 0);
    host_tx(8'hB2);
    status("R3 byte tx drop");
    mon_tag = "R3";
    eng_pop();
    status("R10 tx drained");

    // R9 overrun in byte mode, R4 empty read
    mon_tag = "R9";
    eng_push(8'h11);
    eng_push(8'h22);
    status("R9 overrun set");
    host_rd();
    host_rd();
    status("R4 empty read");
    eng_push(8'h5C);
    mon_tag = "R4";
    host_rd();
    status("R9 overrun sticky");
    clr_ovr();
    status("R9 overrun cleared");

    // R6 flush request in byte mode ignored
    eng_push(8'h33);
    cfg(3'b010);
    chk("R6 pending stays 0", int'(cfg_rdata[1]), 0);
    @(posedge clk); #1;
    status("R6 byte kept");
    mon_tag = "R6";
    host_rd();

    // R8 mode change flushes receive side only
    eng_push(8'h44);
    host_tx(8'h55);
    depth_sel = 1'b0;
    cfg(3'b001);
    chk("R8 rx flush pending", int'(cfg_rdata[1]), 1);
    @(posedge clk); #1;
    chk("R5 pending cleared", int'(cfg_rdata[1]), 0);
    chk("R2 mode readback", int'(cfg_rdata), 1);
    status("R8 after mode change");
    mon_tag = "R8";
    eng_pop();

    // R2 depth 16, R3 overfill, R12 order
    mon_tag = "R12";
    for (int i = 0; i < 20; i++) host_tx(8'(8'h30 + i));
    status("R2 fifo16 full");
    for (int i = 0; i < 16; i++) eng_pop();
    status("R12 tx fifo16 drained");

    // R9 overrun at depth 16, R5 receive flush
    for (int i = 0; i < 17; i++) eng_push(8'(8'h80 + i));
    status("R9 fifo16 overrun");
    for (int i = 0; i < 5; i++) host_rd();
    status("R10 rx partial");
    cfg(3'b011);
    chk("R5 flush pending", int'(cfg_rdata[1]), 1);
    @(posedge clk); #1;
    chk("R5 pending self clear", int'(cfg_rdata[1]), 0);
    status("R5 rx flushed");
    clr_ovr();

    // R2 depth 128 without mode change, R7 transmit flush
    depth_sel = 1'b1;
    cfg(3'b001);
    chk("R2 deep readback", int'(cfg_rdata), 9);
    for (int i = 0; i < 130; i++) host_tx(8'(i));
    status("R2 fifo128 full");
    cfg(3'b101);
    chk("R7 tx flush pending", int'(cfg_rdata[2]), 1);
    @(posedge clk); #1;
    chk("R7 tx pending self clear", int'(cfg_rdata[2]), 0);
    status("R7 tx flushed");

    // R12 pointer wrap on receive
    for (int i = 0; i < 100; i++) eng_push(8'(i + 7));
    for (int i = 0; i < 100; i++) host_rd();
    for (int i = 0; i < 129; i++) eng_push(8'(i * 3));
    status("R12 wrap full");
    for (int i = 0; i < 128; i++) host_rd();
    status("R12 wrap drained");
    clr_ovr();

    // R8 FIFO to byte flushes receive, keeps transmit
    host_tx(8'hE7);
    for (int i = 0; i < 3; i++) eng_push(8'(8'hC0 + i));
    cfg(3'b000);
    @(posedge clk); #1;
    status("R8 back to byte");
    tsr_empty = 1'b0;
    mon_tag = "R11";
    eng_pop();
    @(negedge clk); #3;
    chk("R11 empty but shifting", int'(tx_idle), 0);
    tsr_empty = 1'b1;
    @(negedge clk); #3;
    chk("R11 idle", int'(tx_idle), 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule